// File: doc/BRIEF.md
# Repeat-Mode DMA Channel Sequencer

This block is the address and count engine of a single DMA channel running in repeat transfer mode. Every accepted transfer request moves one data unit. For each such unit the block reports the source and destination addresses of the transfer. It then steps each address side by the access size, or leaves it fixed.

Two counters run alongside the addresses. The block counter counts units within a repeat block. When a block completes, the side chosen as the repeat area is reloaded with its start address. The total counter ends the channel when it runs out. A total of zero instead lets the channel run until software turns it off. When the repeat-stop option is set, the channel halts on the first request after a block ends, raises an end-status flag and can interrupt.

Software programs the channel through a small register write port. A bus-access stub raises a one-cycle request for each unit and receives a one-cycle acknowledge with the addresses.

Top module: `rpt_dma_seq`

## Requirements
- R1: A one-cycle `req` while the channel is enabled and not stop-pending gives exactly one `ack` pulse in the following cycle. `src_addr` and `dst_addr` then hold the addresses of that transfer.
- R2: After each transfer, an address side whose increment bit is set advances by the access size; a side whose bit is clear stays fixed. The size field (control bits 4:3) encodes 0 as 1 byte, 1 as 2 bytes, and 2 or 3 as 4 bytes. The source increment bit is control bit 5 and the destination increment bit is bit 6.
- R3: The area field (control bits 2:1) selects the repeat side: 2 selects source, 1 selects destination, 0 or 3 selects neither. After the last unit of a repeat block, the selected side is reloaded with its start address.
- R4: The repeat-size register (offset 3) sets the block length in units, and a value of 0 means 2^RCNT_W units. The block counter reloads at the start of every block.
- R5: With a non-zero total count (offset 2), the final transfer comes with a one-cycle `xfer_end` pulse, and `chan_en` drops in the same cycle.
- R6: A total count of 0 runs freely. `chan_en` stays high over any number of transfers until software writes the control register with bit 0 clear.
- R7: With control bit 7 set, the first request after a completed block moves no data and gives no `ack`. Instead it clears `chan_en` and sets `end_flag`. A control write clears `end_flag`.
- R8: `irq` is high exactly while `end_flag` is set and control bit 8 is 1.
- R9: With neither side repeating, the addresses run linearly across block boundaries, and `blk_end` pulses together with the `ack` of each block's last unit.
- R10: Requests while `chan_en` is low are ignored: no `ack` and no change of address or counter state.
- R11: After reset, `chan_en`, `ack`, `end_flag`, `irq`, `blk_end` and `xfer_end` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register offset: 0 source start, 1 destination start, 2 total count, 3 repeat size, 4 control |
| cfg_wdata | input | 32 | Write data; a control write with bit 0 set loads working addresses and counters |
| req | input | 1 | One-cycle transfer request from the bus stub |
| ack | output | 1 | One-cycle acknowledge of a transferred unit |
| src_addr | output | ADDR_W | Source address of the acknowledged unit |
| dst_addr | output | ADDR_W | Destination address of the acknowledged unit |
| blk_end | output | 1 | Pulses with the ack of a repeat block's last unit |
| xfer_end | output | 1 | Pulses with the ack of the final unit of a finite total |
| chan_en | output | 1 | Channel enable (control bit 0) |
| end_flag | output | 1 | End-status flag set by a repeat-stop |
| irq | output | 1 | Status interrupt |

## Verification
A corrupted working address shows on `src_addr` or `dst_addr` at the very next acknowledge. A wrong reload after a block shows on the first unit of the next block. A block counter that drifts moves the `blk_end` pulse, and with the repeat-stop set it also moves the halt. Both show within one block of the fault. A wrong total count shifts the `xfer_end` pulse and the drop of `chan_en`. In free-running mode it instead makes the channel stop early. The scoreboard compares every acknowledge against an independent model. That catches a missing or extra acknowledge at the cycle it happens.

// File: rtl/rpt_dma_pkg.sv
package rpt_dma_pkg;

   localparam logic [2:0] OFF_SRC  = 3'd0;
   localparam logic [2:0] OFF_DST  = 3'd1;
   localparam logic [2:0] OFF_TOT  = 3'd2;
   localparam logic [2:0] OFF_RSZ  = 3'd3;
   localparam logic [2:0] OFF_CTRL = 3'd4;

   typedef enum logic [1:0] {
      AREA_NONE = 2'd0,
      AREA_DST  = 2'd1,
      AREA_SRC  = 2'd2,
      AREA_NIL  = 2'd3
   } area_e;

   typedef struct packed {
      logic       sie;
      logic       rie;
      logic       dinc;
      logic       sinc;
      logic [1:0] size;
      area_e      area;
      logic       en;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
      case (sz)
         2'd0:    unit_bytes = 3'd1;
         2'd1:    unit_bytes = 3'd2;
         default: unit_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/rpt_dma_addr.sv
module rpt_dma_addr #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              adv,
   input  logic              wrap,
   input  logic              rep,
   input  logic              inc,
   input  logic [2:0]        stp,
   input  logic [ADDR_W-1:0] start,
   output logic [ADDR_W-1:0] cur
);

   localparam logic [ADDR_W-1:0] ZERO = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cur <= ZERO;
      else if (load)
         cur <= start;
      else if (adv) begin
         if (wrap && rep)
            cur <= start;
         else if (inc)
            cur <= cur + ADDR_W'(stp);
      end
   end

   AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && wrap && rep && !load) |=> (cur == $past(start))); // R3

   AST_FIXED_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !inc && !(wrap && rep) && !load) |=> $stable(cur)); // R2

endmodule

// File: rtl/rpt_dma_cnt.sv
module rpt_dma_cnt #(
   parameter int TCNT_W = 32,
   parameter int RCNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              adv,
   input  logic [RCNT_W-1:0] rsize,
   input  logic [TCNT_W-1:0] total,
   output logic              blk_last,
   output logic              tot_last,
   output logic              free_run
);

   localparam int            BC_W = RCNT_W + 1;
   localparam logic [BC_W-1:0] BC_MAX = BC_W'(1) << RCNT_W;

   logic [BC_W-1:0]   bcnt;
   logic [TCNT_W-1:0] tcnt;
   logic [BC_W-1:0]   reload;

   assign reload   = (rsize == '0) ? BC_MAX : {1'b0, rsize};
   assign blk_last = (bcnt == BC_W'(1));
   assign tot_last = !free_run && (tcnt == TCNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt     <= BC_W'(1);
         tcnt     <= '0;
         free_run <= 1'b1;
      end else if (load) begin
         bcnt     <= reload;
         tcnt     <= total;
         free_run <= (total == '0);
      end else if (adv) begin
         bcnt <= blk_last ? reload : bcnt - BC_W'(1);
         if (!free_run)
            tcnt <= tcnt - TCNT_W'(1);
      end
   end

   AST_BLOCK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (bcnt != '0) && (bcnt <= BC_MAX)); // R4

   AST_BLOCK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && blk_last && !load) |=> (bcnt == $past(reload))); // R4

endmodule

// File: rtl/rpt_dma_seq.sv
module rpt_dma_seq
   import rpt_dma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int TCNT_W = 32,
   parameter int RCNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              req,
   output logic              ack,
   output logic [ADDR_W-1:0] src_addr,
   output logic [ADDR_W-1:0] dst_addr,
   output logic              blk_end,
   output logic              xfer_end,
   output logic              chan_en,
   output logic              end_flag,
   output logic              irq
);

   localparam int NSIDE = 2;

   if (ADDR_W < 3 || ADDR_W > 32) begin : g_bad_addr
      $error("rpt_dma_seq: ADDR_W out of range");
   end
   if (TCNT_W < 2 || TCNT_W > 32) begin : g_bad_tcnt
      $error("rpt_dma_seq: TCNT_W out of range");
   end
   if (RCNT_W < 1 || RCNT_W > 31) begin : g_bad_rcnt
      $error("rpt_dma_seq: RCNT_W out of range");
   end

   ctrl_t             ctl;
   logic [ADDR_W-1:0] start_q [NSIDE];
   logic [ADDR_W-1:0] cur     [NSIDE];
   logic [NSIDE-1:0]  side_rep, side_inc;
   logic [TCNT_W-1:0] total_q;
   logic [RCNT_W-1:0] rsize_q;
   logic              stop_pend;
   logic              ctl_wr, load, go, halt;
   logic              blk_last, tot_last, free_run;
   logic [2:0]        stp;

   assign ctl_wr = cfg_we && (cfg_addr == OFF_CTRL);
   assign load   = ctl_wr && cfg_wdata[0];
   assign go     = ctl.en && req && !stop_pend && !ctl_wr;
   assign halt   = ctl.en && req &&  stop_pend && !ctl_wr;
   assign stp    = unit_bytes(ctl.size);

   assign side_rep[0] = (ctl.area == AREA_SRC);
   assign side_rep[1] = (ctl.area == AREA_DST);
   assign side_inc[0] = ctl.sinc;
   assign side_inc[1] = ctl.dinc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q[0] <= '0;
         start_q[1] <= '0;
         total_q    <= '0;
         rsize_q    <= '0;
      end else if (cfg_we) begin
         case (cfg_addr)
            OFF_SRC: start_q[0] <= cfg_wdata[ADDR_W-1:0];
            OFF_DST: start_q[1] <= cfg_wdata[ADDR_W-1:0];
            OFF_TOT: total_q    <= cfg_wdata[TCNT_W-1:0];
            OFF_RSZ: rsize_q    <= cfg_wdata[RCNT_W-1:0];
            default: ;
         endcase
      end
   end

   for (genvar s = 0; s < NSIDE; s++) begin : g_side
      rpt_dma_addr #(.ADDR_W(ADDR_W)) u_addr (
         .clk   (clk),
         .rst_n (rst_n),
         .load  (load),
         .adv   (go),
         .wrap  (blk_last),
         .rep   (side_rep[s]),
         .inc   (side_inc[s]),
         .stp   (stp),
         .start (start_q[s]),
         .cur   (cur[s])
      );
   end

   rpt_dma_cnt #(.TCNT_W(TCNT_W), .RCNT_W(RCNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .adv      (go),
      .rsize    (rsize_q),
      .total    (total_q),
      .blk_last (blk_last),
      .tot_last (tot_last),
      .free_run (free_run)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl       <= '0;
         end_flag  <= 1'b0;
         stop_pend <= 1'b0;
         ack       <= 1'b0;
         blk_end   <= 1'b0;
         xfer_end  <= 1'b0;
         src_addr  <= '0;
         dst_addr  <= '0;
      end else begin
         ack      <= go;
         blk_end  <= go && blk_last;
         xfer_end <= go && tot_last;
         if (go) begin
            src_addr <= cur[0];
            dst_addr <= cur[1];
         end
         if (ctl_wr) begin
            ctl       <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            end_flag  <= 1'b0;
            stop_pend <= 1'b0;
         end else begin
            if ((go && tot_last) || halt)
               ctl.en <= 1'b0;
            if (halt)
               end_flag <= 1'b1;
            if (go && blk_last && ctl.rie)
               stop_pend <= 1'b1;
         end
      end
   end

   assign chan_en = ctl.en;
   assign irq     = end_flag && ctl.sie;

   AST_ACK_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(req)); // R1

   AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(chan_en)); // R10

   AST_END_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_end |-> (ack && !chan_en)); // R5

   AST_STOP_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(end_flag) |-> (!chan_en && !ack)); // R7

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> end_flag); // R8

endmodule

// File: tb/rpt_dma_seq_test.sv
module rpt_dma_seq_test;

   localparam int AW = 32;
   localparam int RW = 4;

   typedef struct packed {
      logic [AW-1:0] s;
      logic [AW-1:0] d;
      logic          blk;
      logic          tend;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic          req = 1'b0;
   logic          ack, blk_end, xfer_end, chan_en, end_flag, irq;
   logic [AW-1:0] src_addr, dst_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   item_t sb[$];

   // bench model state
   logic [AW-1:0] m_s0, m_d0, m_s, m_d;
   int            m_rl, m_rc, m_tc, m_stp;
   bit            m_free, m_rs, m_rd, m_si, m_di;

   always #2.5 clk = ~clk;

   rpt_dma_seq #(.ADDR_W(AW), .TCNT_W(32), .RCNT_W(RW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .req(req), .ack(ack), .src_addr(src_addr),
      .dst_addr(dst_addr), .blk_end(blk_end), .xfer_end(xfer_end),
      .chan_en(chan_en), .end_flag(end_flag), .irq(irq)
   );

   task automatic check(input string rq, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", rq, got, exp);
      end
   endtask

   // monitor: pops expected transfers on every acknowledge
   always @(negedge clk) begin
      if (rst_n && ack) begin
         if (sb.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R10: got unexpected ack expected none");
         end else begin
            item_t e;
            e = sb.pop_front();
            check("R1/R2/R3 src", src_addr, e.s);
            check("R1/R2/R3 dst", dst_addr, e.d);
            check("R4/R9 blk_end", blk_end, e.blk);
            check("R5 xfer_end", xfer_end, e.tend);
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic setup(input logic [31:0] s0, input logic [31:0] d0, input int tot,
                        input int rsz, input logic [1:0] area, input logic [1:0] sz,
                        input bit si, input bit di, input bit rie, input bit sie);
      wr(3'd0, s0); wr(3'd1, d0); wr(3'd2, tot); wr(3'd3, rsz);
      m_s0 = s0; m_d0 = d0; m_s = s0; m_d = d0;
      m_rl = (rsz == 0) ? (1 << RW) : rsz; m_rc = m_rl;
      m_tc = tot; m_free = (tot == 0);
      m_rs = (area == 2'd2); m_rd = (area == 2'd1);
      m_si = si; m_di = di;
      m_stp = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      wr(3'd4, {23'd0, sie, rie, di, si, sz, area, 1'b1});
   endtask

   task automatic xfer;
      item_t e;
      bit last;
      last   = (m_rc == 1);
      e.s    = m_s; e.d = m_d; e.blk = last;
      e.tend = !m_free && (m_tc == 1);
      sb.push_back(e);
      m_s = (last && m_rs) ? m_s0 : (m_si ? m_s + AW'(m_stp) : m_s);
      m_d = (last && m_rd) ? m_d0 : (m_di ? m_d + AW'(m_stp) : m_d);
      m_rc = last ? m_rl : m_rc - 1;
      if (!m_free) m_tc--;
      @(negedge clk); req = 1'b1;
      @(negedge clk); req = 1'b0;
   endtask

   task automatic bare_req;
      @(negedge clk); req = 1'b1;
      @(negedge clk); req = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 chan_en", chan_en, 0);
      check("R11 ack", ack, 0);
      check("R11 end_flag", end_flag, 0);
      check("R11 irq", irq, 0);
      check("R11 blk_end/xfer_end", {blk_end, xfer_end}, 0);
      rst_n = 1'b1;

      // R10: request while disabled
      bare_req;
      @(negedge clk);
      check("R10 chan_en", chan_en, 0);

      // R3 source repeat, 4-byte, block 3, total 7 -> R5 end
      setup(32'h1000, 32'h8000, 7, 3, 2'd2, 2'd2, 1, 1, 0, 0);
      repeat (7) xfer;
      check("R5 chan_en after final", chan_en, 0);
      bare_req;                               // R10 after end: ignored
      @(negedge clk);
      check("R10 no ack after end", sb.size(), 0);

      // R3 destination repeat, 2-byte, source fixed, free running (R6)
      setup(32'h2000, 32'h9000, 0, 2, 2'd1, 2'd1, 0, 1, 0, 0);
      repeat (9) xfer;
      check("R6 chan_en free run", chan_en, 1);
      wr(3'd4, 32'h0);
      check("R6 chan_en cleared", chan_en, 0);

      // R4: size field 0 -> 16 units, source repeat, byte size
      setup(32'h3000, 32'h4000, 20, 0, 2'd2, 2'd0, 1, 1, 0, 0);
      repeat (20) xfer;
      check("R4 end after 20", chan_en, 0);

      // R9/R7/R8: neither side, block 2, repeat stop with irq
      setup(32'h5000, 32'h6000, 10, 2, 2'd3, 2'd0, 1, 1, 1, 1);
      repeat (2) xfer;
      check("R7 still enabled at block end", chan_en, 1);
      bare_req;
      @(negedge clk);
      check("R7 chan_en cleared", chan_en, 0);
      check("R7 end_flag", end_flag, 1);
      check("R8 irq", irq, 1);
      wr(3'd4, 32'h0);
      check("R7 flag cleared by ctrl write", end_flag, 0);
      check("R8 irq low", irq, 0);

      // R8: status irq disabled, R9 linear across blocks
      setup(32'h7000, 32'h7800, 0, 3, 2'd0, 2'd1, 1, 0, 1, 0);
      repeat (3) xfer;
      bare_req;
      @(negedge clk);
      check("R7 end_flag sie off", end_flag, 1);
      check("R8 irq masked", irq, 0);

      // R9 without stop: linear addresses across several blocks
      setup(32'hA000, 32'hB000, 9, 2, 2'd0, 2'd2, 1, 1, 0, 0);
      repeat (9) xfer;

      repeat (3) @(negedge clk);
      check("scoreboard drained", sb.size(), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule